// File: doc/BRIEF.md
# DRAM Refresh and Initialisation Sequencer

This block owns every refresh-related strobe movement of an asynchronous DRAM. It shares the strobe bus with a separate access controller through a request/grant pair, and drives a strobe only while it holds the grant. After reset it waits a programmable power-up time. It then runs a fixed number of wake-up cycles, each one a column-before-row refresh, and only after those cycles does it report that the memory is ready.

In normal operation it issues one distributed column-before-row refresh each time a programmable idle interval expires. On command it places the DRAM in self-refresh by starting a column-before-row cycle and keeping both strobe groups low. It brings the DRAM out again with a row-strobe-high recovery period, and the normal interval resumes with no burst of catch-up refreshes.

A watchdog limits how long a refresh request may wait for the grant. If the grant does not arrive in time, the deadline counts as missed: the sequencer flags the overrun, drops its ready indication and repeats the whole wake-up sequence. The address and data buses are never touched.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is low, and for T_INIT cycles after it is released, `ras_n` is 1, every `cas_n` bit is 1, and `refresh_req`, `init_done`, `overrun` and `in_selfref` are 0. Reset is synchronous and active low.
- R2: `refresh_req` rises before any strobe moves. No strobe falls until the cycle after `refresh_gnt` has been sampled high. `refresh_req` stays high until the strobe activity and its recovery time are complete.
- R3: Every refresh is column-before-row. All `cas_n` bits go low for T_CSR cycles while `ras_n` is high. `ras_n` then falls, the column strobes stay low for T_CHR more cycles, and `ras_n` stays low for T_RAS cycles in total.
- R4: After each ordinary refresh, `ras_n` and `cas_n` are held high for T_RP cycles with `refresh_req` still high. During wake-up with an immediate grant, the row strobe therefore stays high for T_RP+1+T_CSR cycles between two falls.
- R5: After the power-up wait, exactly WAKE_CYCLES refreshes are issued. `init_done` rises in the same cycle that the last recovery period ends.
- R6: Once `init_done` is high and no self-refresh is requested, a new request is raised after exactly T_IVL cycles with `refresh_req` low following the previous refresh.
- R7: If a request waits T_DL cycles without a grant while `init_done` is high, `overrun` sets and `init_done` clears while the request stays raised. A full new set of WAKE_CYCLES refreshes is then issued, and `overrun` clears when `init_done` returns.
- R8: If `sr_req` is high in an idle cycle, a column-before-row cycle starts whose strobes then stay low with `in_selfref` high. This hold lasts at least T_SRMIN cycles and for as long as `sr_req` stays high.
- R9: On leaving self-refresh, `ras_n` and `cas_n` are high for T_SRX cycles with `refresh_req` still high. The request then drops, and the next refresh request follows after exactly T_IVL cycles.
- R10: During the power-up wait, `refresh_gnt` and `sr_req` have no effect on the strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| refresh_gnt | input | 1 | Bus granted by the access controller |
| sr_req | input | 1 | Level request to enter and stay in self-refresh |
| refresh_req | output | 1 | Sequencer needs or holds the strobe bus |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | CAS_LANES | Column strobes, one per byte lane, active low |
| init_done | output | 1 | Wake-up sequence finished, normal access allowed |
| overrun | output | 1 | Refresh deadline missed, re-initialisation running |
| in_selfref | output | 1 | DRAM held in self-refresh |

## Verification
The refresh machinery is driven in several ways:
- An immediate grant shows the exact strobe ordering and the precharge spacing.
- A withheld grant separates a correct deadline count from a late one and shows that the wake-up sequence is repeated.
- A one-cycle self-refresh request shows that the minimum hold time is enforced.
- A request held for a long time shows that the DRAM stays in self-refresh while `sr_req` is high.

Toggling the grant and the self-refresh input during the power-up wait shows that neither can disturb the strobes early. The gap measured after init and after self-refresh exit shows whether the interval timer restarts with no catch-up refresh.

// File: rtl/dram_rfsh_pkg.sv
`timescale 1ns/1ps
// Shared types for the DRAM refresh sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package dram_rfsh_pkg;
    // Sequencer phases; each maps to one fixed strobe pattern
    typedef enum logic [3:0] {
        PH_PWR,   // power-up wait, bus untouched
        PH_REQ,   // request raised, waiting for grant
        PH_LEAD,  // column strobes low, row strobe high
        PH_BOTH,  // both strobes low
        PH_RASO,  // row strobe low only
        PH_PRE,   // precharge, all strobes high
        PH_IDLE,  // normal operation, bus released
        PH_SRH,   // self-refresh hold
        PH_SRX    // self-refresh exit recovery
    } rf_phase_e;
endpackage

// File: rtl/rfsh_interval_timer.sv
`timescale 1ns/1ps
// Interval timer: counts idle cycles and flags when a refresh is due.
// Assumes: run is high only while the sequencer is idle; leaving idle clears it.
module rfsh_interval_timer #(
    parameter int T_IVL = 760
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic due
);
    localparam int IW = $clog2(T_IVL + 1);
    localparam logic [IW-1:0] L_LAST = IW'(T_IVL - 1);

    logic [IW-1:0] ivl;

    // count idle cycles, restart whenever the sequencer leaves idle
    always_ff @(posedge clk) begin
        if (!rst_n)   ivl <= '0;
        else if (run) ivl <= ivl + 1'b1;
        else          ivl <= '0;
    end

    assign due = run && (ivl == L_LAST);

    // R6: the sequencer always leaves idle once the interval has expired
    ivl_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> ivl <= L_LAST);
endmodule

// File: rtl/rfsh_phase_fsm.sv
`timescale 1ns/1ps
// Phase sequencer: power-up wait, wake cycles, distributed CBR refresh,
// self-refresh entry/exit and missed-deadline re-initialisation.
// Assumes: T_RAS > T_CHR, all timing parameters >= 1, T_INIT >= T_RP.
module rfsh_phase_fsm
    import dram_rfsh_pkg::*;
#(
    parameter int WAKE_CYCLES = 8,
    parameter int T_INIT      = 10000,
    parameter int T_CSR       = 1,
    parameter int T_CHR       = 1,
    parameter int T_RAS       = 3,
    parameter int T_RP        = 2,
    parameter int T_SRMIN     = 5000,
    parameter int T_SRX       = 6,
    parameter int T_DL        = 1000
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      refresh_gnt,
    input  logic      sr_req,
    input  logic      due,
    output rf_phase_e phase,
    output logic      init_done,
    output logic      overrun
);
    localparam int CW = $clog2(T_INIT + T_SRMIN + T_DL + T_RAS + T_RP + T_CSR + T_SRX + 2);
    localparam int WW = $clog2(WAKE_CYCLES + 1);
    localparam logic [CW-1:0] L_INIT  = CW'(T_INIT - 1);
    localparam logic [CW-1:0] L_CSR   = CW'(T_CSR - 1);
    localparam logic [CW-1:0] L_CHR   = CW'(T_CHR - 1);
    localparam logic [CW-1:0] L_RHD   = CW'(T_RAS - T_CHR - 1);
    localparam logic [CW-1:0] L_RP    = CW'(T_RP - 1);
    localparam logic [CW-1:0] L_SRMIN = CW'(T_SRMIN - 1);
    localparam logic [CW-1:0] L_SRX   = CW'(T_SRX - 1);
    localparam logic [CW-1:0] L_DL    = CW'(T_DL - 1);
    localparam logic [WW-1:0] L_WAKE  = WW'(WAKE_CYCLES - 1);

    logic [CW-1:0] cnt;
    logic [WW-1:0] wake_cnt;
    logic          sr_mode;

    // phase transitions with a shared per-phase cycle counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_PWR;
            cnt       <= '0;
            wake_cnt  <= '0;
            init_done <= 1'b0;
            overrun   <= 1'b0;
            sr_mode   <= 1'b0;
        end else begin
            unique case (phase)
                PH_PWR: begin
                    if (cnt == L_INIT) begin
                        phase <= PH_REQ;
                        cnt   <= '0;
                    end else cnt <= cnt + 1'b1;
                end
                PH_REQ: begin
                    if (refresh_gnt) begin
                        phase <= PH_LEAD;
                        cnt   <= '0;
                    end else if (init_done && cnt == L_DL) begin
                        overrun   <= 1'b1;
                        init_done <= 1'b0;
                        wake_cnt  <= '0;
                        sr_mode   <= 1'b0;
                        cnt       <= '0;
                    end else cnt <= cnt + 1'b1;
                end
                PH_LEAD: begin
                    if (cnt == L_CSR) begin
                        phase <= PH_BOTH;
                        cnt   <= '0;
                    end else cnt <= cnt + 1'b1;
                end
                PH_BOTH: begin
                    if (cnt == L_CHR) begin
                        phase <= sr_mode ? PH_SRH : PH_RASO;
                        cnt   <= '0;
                    end else cnt <= cnt + 1'b1;
                end
                PH_RASO: begin
                    if (cnt == L_RHD) begin
                        phase <= PH_PRE;
                        cnt   <= '0;
                    end else cnt <= cnt + 1'b1;
                end
                PH_PRE: begin
                    if (cnt == L_RP) begin
                        cnt <= '0;
                        if (init_done) begin
                            phase <= PH_IDLE;
                        end else begin
                            wake_cnt <= wake_cnt + 1'b1;
                            if (wake_cnt == L_WAKE) begin
                                init_done <= 1'b1;
                                overrun   <= 1'b0;
                                phase     <= PH_IDLE;
                            end else phase <= PH_REQ;
                        end
                    end else cnt <= cnt + 1'b1;
                end
                PH_IDLE: begin
                    if (sr_req || due) begin
                        sr_mode <= sr_req;
                        phase   <= PH_REQ;
                        cnt     <= '0;
                    end
                end
                PH_SRH: begin
                    if (cnt == L_SRMIN) begin
                        if (!sr_req) begin
                            phase <= PH_SRX;
                            cnt   <= '0;
                        end
                    end else cnt <= cnt + 1'b1;
                end
                PH_SRX: begin
                    if (cnt == L_SRX) begin
                        phase   <= PH_IDLE;
                        sr_mode <= 1'b0;
                        cnt     <= '0;
                    end else cnt <= cnt + 1'b1;
                end
                default: phase <= PH_PWR;
            endcase
        end
    end

    // R2
    grant_before_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_LEAD && $past(phase) != PH_LEAD) |-> $past(refresh_gnt));
    // R5
    ready_after_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> (wake_cnt == WW'(WAKE_CYCLES) && $past(phase) == PH_PRE));
    // R7
    overrun_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> (!init_done && phase == PH_REQ));
    // R8
    sr_only_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SRH) |-> init_done);
endmodule

// File: rtl/rfsh_strobe_drv.sv
`timescale 1ns/1ps
// Strobe decoder: turns the current phase into strobe levels and status.
// Assumes: phase is a registered value, so outputs are glitch-free per cycle.
module rfsh_strobe_drv
    import dram_rfsh_pkg::*;
#(
    parameter int CAS_LANES = 2
) (
    input  rf_phase_e             phase,
    output logic                  ras_n,
    output logic [CAS_LANES-1:0]  cas_n,
    output logic                  refresh_req,
    output logic                  in_selfref
);
    logic col_low;
    logic row_low;

    // decide which strobe groups are active in this phase
    always_comb begin
        col_low     = phase inside {PH_LEAD, PH_BOTH, PH_SRH};
        row_low     = phase inside {PH_BOTH, PH_RASO, PH_SRH};
        refresh_req = !(phase inside {PH_PWR, PH_IDLE});
        in_selfref  = (phase == PH_SRH);
    end

    assign ras_n = !row_low;

    // every byte lane takes part in the CBR cycle
    for (genvar g = 0; g < CAS_LANES; g++) begin : g_lane
        assign cas_n[g] = !col_low;
    end
endmodule

// File: rtl/dram_refresh_seq.sv
`timescale 1ns/1ps
// DRAM refresh and init sequencer top: interval timer, phase sequencer and
// strobe decoder, with timing checkers on the strobe pins.
// Assumes: the access controller releases the strobes while refresh_gnt is high.
module dram_refresh_seq
    import dram_rfsh_pkg::*;
#(
    parameter int CAS_LANES   = 2,
    parameter int WAKE_CYCLES = 8,
    parameter int T_INIT      = 10000,
    parameter int T_IVL       = 760,
    parameter int T_CSR       = 1,
    parameter int T_CHR       = 1,
    parameter int T_RAS       = 3,
    parameter int T_RP        = 2,
    parameter int T_SRMIN     = 5000,
    parameter int T_SRX       = 6,
    parameter int T_DL        = 1000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 refresh_gnt,
    input  logic                 sr_req,
    output logic                 refresh_req,
    output logic                 ras_n,
    output logic [CAS_LANES-1:0] cas_n,
    output logic                 init_done,
    output logic                 overrun,
    output logic                 in_selfref
);
    rf_phase_e phase;
    logic      due;
    logic      idle_run;

    assign idle_run = (phase == PH_IDLE);

    rfsh_interval_timer #(.T_IVL(T_IVL)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(idle_run), .due(due)
    );

    rfsh_phase_fsm #(
        .WAKE_CYCLES(WAKE_CYCLES), .T_INIT(T_INIT), .T_CSR(T_CSR),
        .T_CHR(T_CHR), .T_RAS(T_RAS), .T_RP(T_RP), .T_SRMIN(T_SRMIN),
        .T_SRX(T_SRX), .T_DL(T_DL)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .refresh_gnt(refresh_gnt), .sr_req(sr_req),
        .due(due), .phase(phase), .init_done(init_done), .overrun(overrun)
    );

    rfsh_strobe_drv #(.CAS_LANES(CAS_LANES)) u_drv (
        .phase(phase), .ras_n(ras_n), .cas_n(cas_n),
        .refresh_req(refresh_req), .in_selfref(in_selfref)
    );

    // checker counters for the windows that are too long for $past
    localparam int HW = $clog2(T_RP + 1);
    localparam int SW = $clog2(T_SRMIN + 1);
    localparam logic [HW-1:0] H_MAX = HW'(T_RP);
    localparam logic [SW-1:0] S_MAX = SW'(T_SRMIN);
    logic [HW-1:0] hi_len;
    logic [SW-1:0] sr_len;

    // track the length of the current row-strobe-high and self-refresh runs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_len <= '0;
            sr_len <= '0;
        end else begin
            hi_len <= !ras_n ? '0 : (hi_len == H_MAX ? hi_len : hi_len + 1'b1);
            sr_len <= !in_selfref ? '0 : (sr_len == S_MAX ? sr_len : sr_len + 1'b1);
        end
    end

    // R2
    strobe_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n || cas_n != '1) |-> refresh_req);
    // R3
    cbr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> ($past(cas_n) == '0 && cas_n == '0));
    // R4
    precharge_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> hi_len >= H_MAX);
    // R8
    sr_min_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_selfref) |-> sr_len >= S_MAX);
    // R8
    sr_strobes_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_selfref |-> (!ras_n && cas_n == '0));
endmodule

// File: tb/dram_refresh_seq_test.sv
`timescale 1ns/1ps
module dram_refresh_seq_test;
    localparam int P_WAKE = 8, P_INIT = 20, P_IVL = 30, P_CSR = 2, P_CHR = 3;
    localparam int P_RAS = 6, P_RP = 4, P_SRMIN = 15, P_SRX = 5, P_DL = 10;

    logic clk = 0, rst_n = 0, refresh_gnt = 0, sr_req = 0;
    logic refresh_req, ras_n, init_done, overrun, in_selfref;
    logic [1:0] cas_n;
    bit force_gnt = 0, gnt_en = 1, cmp_on = 0, finished = 0;
    int checks = 0, fails = 0;

    dram_refresh_seq #(
        .CAS_LANES(2), .WAKE_CYCLES(P_WAKE), .T_INIT(P_INIT), .T_IVL(P_IVL),
        .T_CSR(P_CSR), .T_CHR(P_CHR), .T_RAS(P_RAS), .T_RP(P_RP),
        .T_SRMIN(P_SRMIN), .T_SRX(P_SRX), .T_DL(P_DL)
    ) uut (
        .clk(clk), .rst_n(rst_n), .refresh_gnt(refresh_gnt), .sr_req(sr_req),
        .refresh_req(refresh_req), .ras_n(ras_n), .cas_n(cas_n),
        .init_done(init_done), .overrun(overrun), .in_selfref(in_selfref)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    // access controller stand-in: grants one cycle after the request is seen
    always @(negedge clk) refresh_gnt <= force_gnt | (refresh_req & gnt_en);

    // behavioural reference model, advanced on every rising edge
    localparam int M_PW = 0, M_WT = 1, M_LD = 2, M_BT = 3, M_RO = 4;
    localparam int M_PR = 5, M_ID = 6, M_SR = 7, M_RC = 8;
    int ph = M_PW, n = 0, wakes = 0, idle_n = 0;
    bit ready = 0, ovr = 0, want_sr = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            ph = M_PW; n = 0; wakes = 0; idle_n = 0; ready = 0; ovr = 0; want_sr = 0;
        end else begin
            case (ph)
                M_PW: if (n == P_INIT - 1) begin ph = M_WT; n = 0; end else n++;
                M_WT: if (refresh_gnt) begin ph = M_LD; n = 0; end
                      else if (ready && n == P_DL - 1) begin
                          ovr = 1; ready = 0; wakes = 0; want_sr = 0; n = 0;
                      end else n++;
                M_LD: if (n == P_CSR - 1) begin ph = M_BT; n = 0; end else n++;
                M_BT: if (n == P_CHR - 1) begin ph = want_sr ? M_SR : M_RO; n = 0; end else n++;
                M_RO: if (n == P_RAS - P_CHR - 1) begin ph = M_PR; n = 0; end else n++;
                M_PR: if (n == P_RP - 1) begin
                          n = 0; idle_n = 0;
                          if (ready) ph = M_ID;
                          else begin
                              wakes++;
                              if (wakes == P_WAKE) begin ready = 1; ovr = 0; ph = M_ID; end
                              else ph = M_WT;
                          end
                      end else n++;
                M_ID: if (sr_req) begin want_sr = 1; ph = M_WT; n = 0; end
                      else if (idle_n == P_IVL - 1) begin want_sr = 0; ph = M_WT; n = 0; end
                      else idle_n++;
                M_SR: if (n >= P_SRMIN - 1) begin
                          if (!sr_req) begin ph = M_RC; n = 0; end
                      end else n++;
                M_RC: if (n == P_SRX - 1) begin ph = M_ID; n = 0; idle_n = 0; want_sr = 0; end else n++;
                default: ph = M_PW;
            endcase
        end
    end

    // compare every cycle, away from the rising edge
    always @(negedge clk) begin
        if (cmp_on) begin
            bit e_ras, e_col, e_req;
            e_ras = !(ph == M_BT || ph == M_RO || ph == M_SR);
            e_col = (ph == M_LD || ph == M_BT || ph == M_SR);
            e_req = !(ph == M_PW || ph == M_ID);
            check(ras_n === e_ras, "R3 ras_n", int'(ras_n), int'(e_ras));
            check(cas_n === (e_col ? 2'b00 : 2'b11), "R3 cas_n", int'(cas_n), e_col ? 0 : 3);
            check(refresh_req === e_req, "R2 refresh_req", int'(refresh_req), int'(e_req));
            check(init_done === ready, "R5 init_done", int'(init_done), int'(ready));
            check(overrun === ovr, "R7 overrun", int'(overrun), int'(ovr));
            check(in_selfref === (ph == M_SR), "R8 in_selfref", int'(in_selfref), int'(ph == M_SR));
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        report();
    end

    // count wake cycles until init_done, checking row-high spacing
    task automatic run_wake(input string tag);
        int falls = 0, run = 0, bad = 0, guard = 0;
        bit prev = 1;
        while (!init_done && guard < 1000) begin
            if (prev && !ras_n) begin
                if (falls > 0 && run != P_RP + 1 + P_CSR) bad++;
                falls++; run = 0;
            end
            if (ras_n) run++;
            prev = ras_n;
            guard++;
            @(negedge clk);
        end
        check(falls == P_WAKE, {tag, " wake cycle count"}, falls, P_WAKE);
        check(bad == 0, "R4 row high spacing during wake", bad, 0);
    endtask

    task automatic gap(input string tag, input int exp);
        int c = 0;
        while (refresh_req == 0 && c < 1000) begin c++; @(negedge clk); end
        check(c == exp, tag, c, exp);
    endtask

    task automatic wait_req_low();
        int g = 0;
        while (refresh_req && g < 1000) begin g++; @(negedge clk); end
    endtask

    initial begin
        int lead, both, low, pre, c;
        repeat (2) @(negedge clk);
        cmp_on = 1;
        // R1 reset values
        check(ras_n == 1 && cas_n == 2'b11, "R1 strobes in reset", {ras_n, cas_n}, 7);
        check(!refresh_req && !init_done && !overrun && !in_selfref, "R1 flags in reset",
              {refresh_req, init_done, overrun, in_selfref}, 0);
        rst_n = 1;
        // R10 grant and self-refresh request ignored during power-up wait
        force_gnt = 1; sr_req = 1;
        c = 0;
        repeat (8) begin @(negedge clk); if (!ras_n || cas_n != 2'b11 || refresh_req) c++; end
        check(c == 0, "R10 strobes idle during wait", c, 0);
        force_gnt = 0; sr_req = 0;
        run_wake("R5");
        // R6 interval after init
        gap("R6 first interval", P_IVL);
        // R3 strobe ordering in a normal refresh
        lead = 0; both = 0; low = 0; pre = 0;
        while (ras_n && lead < 100) begin if (cas_n == 2'b00) lead++; @(negedge clk); end
        while (!ras_n && low < 100) begin low++; if (cas_n == 2'b00) both++; @(negedge clk); end
        check(lead == P_CSR, "R3 column lead", lead, P_CSR);
        check(both == P_CHR, "R3 column hold", both, P_CHR);
        check(low == P_RAS, "R3 row low width", low, P_RAS);
        while (refresh_req && pre < 100) begin pre++; @(negedge clk); end
        check(pre == P_RP, "R4 precharge", pre, P_RP);
        gap("R6 second interval", P_IVL);
        wait_req_low();
        // R7 withheld grant
        gnt_en = 0;
        while (!refresh_req) @(negedge clk);
        c = 0;
        while (!overrun && c < 200) begin c++; @(negedge clk); end
        check(c == P_DL, "R7 deadline length", c, P_DL);
        check(!init_done && refresh_req, "R7 ready dropped, request held",
              {init_done, refresh_req}, 1);
        gnt_en = 1;
        run_wake("R7");
        check(!overrun, "R7 overrun cleared", overrun, 0);
        // R8 short self-refresh request keeps minimum hold
        sr_req = 1;
        c = 0;
        while (!in_selfref && c < 100) begin c++; @(negedge clk); end
        sr_req = 0;
        c = 0;
        while (in_selfref && c < 200) begin c++; @(negedge clk); end
        check(c == P_SRMIN, "R8 minimum hold", c, P_SRMIN);
        // R9 exit recovery then normal interval, no burst
        c = 0;
        while (refresh_req && ras_n && cas_n == 2'b11 && c < 100) begin c++; @(negedge clk); end
        check(c == P_SRX, "R9 exit recovery", c, P_SRX);
        gap("R9 interval after exit", P_IVL);
        wait_req_low();
        // R8 long request holds self-refresh
        sr_req = 1;
        c = 0;
        while (!in_selfref && c < 100) begin c++; @(negedge clk); end
        c = 0;
        repeat (40) begin @(negedge clk); if (in_selfref) c++; end
        check(c == 40, "R8 held while requested", c, 40);
        sr_req = 0;
        @(negedge clk);
        check(!in_selfref && ras_n, "R9 prompt exit", {in_selfref, ras_n}, 1);
        repeat (P_SRX + 2) @(negedge clk);
        report();
    end
endmodule